// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the combinational control for a five-stage in-order integer pipeline. It looks at the register indices read by the instruction in decode and by the instruction in execute. It also looks at the destination index, the write-enable and the load flag of each older instruction still in flight. From these it decides where every execute-stage operand comes from, whether the front of the pipe must wait one cycle, and whether wrong-path instructions must be discarded.

Each execute operand has its own 2-bit select. The operands are ALU input A, ALU input B and the store-data value. A select picks the register-file value, the value held in the memory-stage pipeline register, or the value held in the writeback-stage pipeline register.

A stall is raised only when a load sits in execute and the instruction behind it needs the loaded register. No bypass path can help in that case. A stall holds the PC and the fetch/decode register and turns the next decode/execute entry into a bubble. When the branch comparator reports a taken branch in execute, the fetch/decode and decode/execute registers are flushed, and a stall in the same cycle is dropped.

Top module: `hzc_hazard_unit`

## Requirements
- R1: An execute operand whose index is nonzero and equals `mem_rd`, with `mem_we`=1 and `mem_is_load`=0, gets select 2'b10 (memory-stage bypass).
- R2: An execute operand that has no R1 match, whose index is nonzero and equals `wb_rd` with `wb_we`=1, gets select 2'b01 (writeback-stage bypass).
- R3: When an operand matches both the memory and the writeback stages, the memory stage (2'b10) wins. With neither match, the select is 2'b00 (register file).
- R4: Index 0 never matches. An operand with index 0 always gets 2'b00, and a load with `ex_rd`=0 never stalls.
- R5: A producer whose write-enable is 0 is never a match, for bypass or for stall.
- R6: A memory-stage producer flagged as a load is not bypassed from the memory stage. A writeback-stage match, if one exists, still applies.
- R7: When `ex_is_load`=1, `ex_we`=1, `ex_rd`!=0, and `ex_rd` equals a decode source whose use bit is 1, then `pc_hold`, `ifid_hold` and `idex_bubble` all go to 1 in the same cycle.
- R8: No stall is raised when the execute-stage producer is not a load, or when the matching decode source has its use bit at 0.
- R9: `br_taken`=1 drives both `ifid_flush` and `idex_flush` to 1. With `br_taken`=0 both are 0.
- R10: While `br_taken`=1, `pc_hold`, `ifid_hold` and `idex_bubble` are 0, even if R7 holds.
- R11: The store-data operand (select bits [5:4], index bits [3*AW-1:2*AW]) follows R1 to R6 exactly as the ALU operands do (bits [1:0] for A, [3:2] for B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | NUM_ID_SRC*REG_AW | Decode-stage source indices, source k in bits [k*REG_AW +: REG_AW] |
| id_rs_use | input | NUM_ID_SRC | Bit k is 1 if decode source k is actually read |
| ex_rs | input | NUM_EX_SRC*REG_AW | Execute-stage operand indices: 0 ALU A, 1 ALU B, 2 store data |
| ex_rd | input | REG_AW | Destination of the instruction in execute |
| ex_we | input | 1 | Register write-enable of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination held in the memory-stage register |
| mem_we | input | 1 | Write-enable held in the memory-stage register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination held in the writeback-stage register |
| wb_we | input | 1 | Write-enable held in the writeback-stage register |
| br_taken | input | 1 | Branch resolved taken in execute |
| ex_fwd_sel | output | 2*NUM_EX_SRC | Per-operand select: 00 register file, 01 writeback, 10 memory |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a bubble into decode/execute |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| idex_flush | output | 1 | Clear the decode/execute register |

## Verification
The bench builds the unit with REG_AW=3, which gives eight registers, and keeps the default operand counts. With random indices drawn from only eight values, an operand often matches the memory and writeback destinations at once, and index 0 shows up often. That exercises the priority, x0 and write-enable rules thousands of times instead of rarely. Load-use, branch-over-stall and store-data-only matches also come up often at this width, and directed cases pin each of them once.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } byp_sel_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
        logic ifid_flush;
        logic idex_flush;
    } pipe_ctl_t;

endpackage

// File: rtl/hzc_bypass_pick.sv
module hzc_bypass_pick
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_ld,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output byp_sel_e      sel
);

    typedef struct packed {
        logic     mem_hit;
        logic     wb_hit;
        byp_sel_e sel;
    } pick_t;

    pick_t pick_d;

    always_comb begin
        pick_d         = '0;
        pick_d.mem_hit = (src != '0) && mem_we && !mem_ld && (src == mem_rd);
        pick_d.wb_hit  = (src != '0) && wb_we && (src == wb_rd);
        if (pick_d.mem_hit)
            pick_d.sel = SRC_MEM;
        else if (pick_d.wb_hit)
            pick_d.sel = SRC_WB;
        else
            pick_d.sel = SRC_REGFILE;
    end

    assign sel = pick_d.sel;

    always_comb begin
        // R4
        zero_src_chk: assert (src != '0 || sel == SRC_REGFILE);
        // R1
        mem_src_match_chk: assert (sel != SRC_MEM || (src == mem_rd && mem_we));
        // R6
        no_load_mem_byp_chk: assert (sel != SRC_MEM || !mem_ld);
        // R2
        wb_src_match_chk: assert (sel != SRC_WB || (src == wb_rd && wb_we));
    end

endmodule

// File: rtl/hzc_loaduse_detect.sv
module hzc_loaduse_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC*AW-1:0] id_rs,
    input  logic [NSRC-1:0]    id_use,
    input  logic [AW-1:0]      ex_rd,
    input  logic               ex_we,
    input  logic               ex_ld,
    output logic               hazard
);

    logic [NSRC-1:0] hit_d;
    logic            producer_ok;

    assign producer_ok = ex_ld && ex_we && (ex_rd != '0);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign hit_d[k] = id_use[k] && (id_rs[k*AW +: AW] == ex_rd);
    end

    assign hazard = producer_ok && (|hit_d);

    always_comb begin
        // R8
        load_only_chk: assert (!hazard || ex_ld);
        // R4
        no_x0_stall_chk: assert (!hazard || ex_rd != '0);
        // R5
        we_needed_chk: assert (!hazard || ex_we);
    end

endmodule

// File: rtl/hzc_pipe_ctl.sv
module hzc_pipe_ctl
    import hzc_pkg::*;
(
    input  logic      hazard,
    input  logic      br_taken,
    output pipe_ctl_t ctl
);

    pipe_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        if (br_taken) begin
            ctl_d.ifid_flush = 1'b1;
            ctl_d.idex_flush = 1'b1;
        end else if (hazard) begin
            ctl_d.pc_hold     = 1'b1;
            ctl_d.ifid_hold   = 1'b1;
            ctl_d.idex_bubble = 1'b1;
        end
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/hzc_hazard_unit.sv
module hzc_hazard_unit
    import hzc_pkg::*;
#(
    parameter int REG_AW     = 5,
    parameter int NUM_ID_SRC = 2,
    parameter int NUM_EX_SRC = 3
) (
    input  logic [NUM_ID_SRC*REG_AW-1:0] id_rs,
    input  logic [NUM_ID_SRC-1:0]        id_rs_use,
    input  logic [NUM_EX_SRC*REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0]            ex_rd,
    input  logic                         ex_we,
    input  logic                         ex_is_load,
    input  logic [REG_AW-1:0]            mem_rd,
    input  logic                         mem_we,
    input  logic                         mem_is_load,
    input  logic [REG_AW-1:0]            wb_rd,
    input  logic                         wb_we,
    input  logic                         br_taken,
    output logic [2*NUM_EX_SRC-1:0]      ex_fwd_sel,
    output logic                         pc_hold,
    output logic                         ifid_hold,
    output logic                         idex_bubble,
    output logic                         ifid_flush,
    output logic                         idex_flush
);

    localparam int SEL_W = 2 * NUM_EX_SRC;

    byp_sel_e  sel_d [NUM_EX_SRC];
    logic      hazard_d;
    pipe_ctl_t ctl_d;

    // One selector per execute operand (ALU A, ALU B, store data: R11)
    for (genvar k = 0; k < NUM_EX_SRC; k++) begin : g_op
        hzc_bypass_pick #(.AW(REG_AW)) u_pick (
            .src    (ex_rs[k*REG_AW +: REG_AW]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .mem_ld (mem_is_load),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel_d[k])
        );
        assign ex_fwd_sel[2*k +: 2] = sel_d[k];
    end

    hzc_loaduse_detect #(.AW(REG_AW), .NSRC(NUM_ID_SRC)) u_lu (
        .id_rs  (id_rs),
        .id_use (id_rs_use),
        .ex_rd  (ex_rd),
        .ex_we  (ex_we),
        .ex_ld  (ex_is_load),
        .hazard (hazard_d)
    );

    hzc_pipe_ctl u_ctl (
        .hazard   (hazard_d),
        .br_taken (br_taken),
        .ctl      (ctl_d)
    );

    assign pc_hold     = ctl_d.pc_hold;
    assign ifid_hold   = ctl_d.ifid_hold;
    assign idex_bubble = ctl_d.idex_bubble;
    assign ifid_flush  = ctl_d.ifid_flush;
    assign idex_flush  = ctl_d.idex_flush;

    always_comb begin
        // R7
        stall_trio_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        // R9
        flush_pair_chk: assert (ifid_flush == idex_flush);
        // R10
        flush_over_stall_chk: assert (!(ifid_flush && pc_hold));
        // R3
        sel_code_chk: assert (SEL_W == 2 * NUM_EX_SRC && ex_fwd_sel[1:0] != 2'b11);
    end

endmodule

// File: tb/sim_hzc_hazard_unit.sv
module sim_hzc_hazard_unit;

    localparam int AW = 3;
    localparam int NI = 2;
    localparam int NE = 3;

    logic clk = 1'b0;
    always #10ns clk = ~clk;

    logic [NI*AW-1:0] id_rs       = '0;
    logic [NI-1:0]    id_rs_use   = '0;
    logic [NE*AW-1:0] ex_rs       = '0;
    logic [AW-1:0]    ex_rd       = '0;
    logic             ex_we       = 1'b0;
    logic             ex_is_load  = 1'b0;
    logic [AW-1:0]    mem_rd      = '0;
    logic             mem_we      = 1'b0;
    logic             mem_is_load = 1'b0;
    logic [AW-1:0]    wb_rd       = '0;
    logic             wb_we       = 1'b0;
    logic             br_taken    = 1'b0;
    logic [2*NE-1:0]  ex_fwd_sel;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    hzc_hazard_unit #(.REG_AW(AW), .NUM_ID_SRC(NI), .NUM_EX_SRC(NE)) u0 (
        .id_rs(id_rs), .id_rs_use(id_rs_use), .ex_rs(ex_rs), .ex_rd(ex_rd),
        .ex_we(ex_we), .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_is_load(mem_is_load), .wb_rd(wb_rd), .wb_we(wb_we), .br_taken(br_taken),
        .ex_fwd_sel(ex_fwd_sel), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .ifid_flush(ifid_flush), .idex_flush(idex_flush)
    );

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] rs);
        if (rs != 0 && mem_we && !mem_is_load && rs == mem_rd) return 2'b10;
        if (rs != 0 && wb_we && rs == wb_rd) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input int k, input logic [AW-1:0] rs);
        if (k == 2) return "R11";
        if (rs == 0) return "R4";
        if (rs == mem_rd && mem_we && mem_is_load) return "R6";
        if ((rs == mem_rd && !mem_we) || (rs == wb_rd && !wb_we)) return "R5";
        if (rs == mem_rd && mem_we && rs == wb_rd && wb_we) return "R3";
        if (rs == mem_rd && mem_we) return "R1";
        if (rs == wb_rd && wb_we) return "R2";
        return "R3";
    endfunction

    function automatic logic exp_hazard();
        logic h = 1'b0;
        for (int k = 0; k < NI; k++)
            if (id_rs_use[k] && id_rs[k*AW +: AW] == ex_rd) h = 1'b1;
        return h && ex_is_load && ex_we && ex_rd != 0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic hz;
        logic [2:0] stall_exp;
        string stag;
        @(negedge clk);
        for (int k = 0; k < NE; k++)
            check(sel_tag(k, ex_rs[k*AW +: AW]), $sformatf("sel%0d", k),
                  {6'b0, ex_fwd_sel[2*k +: 2]}, {6'b0, exp_sel(ex_rs[k*AW +: AW])});
        hz = exp_hazard();
        stall_exp = (hz && !br_taken) ? 3'b111 : 3'b000;
        stag = br_taken ? "R10" : (hz ? "R7" : "R8");
        check(stag, "stall", {5'b0, pc_hold, ifid_hold, idex_bubble}, {5'b0, stall_exp});
        check("R9", "flush", {6'b0, ifid_flush, idex_flush}, {6'b0, br_taken, br_taken});
    endtask

    task automatic randomize_inputs();
        @(posedge clk);
        id_rs       = AW'($urandom) | (NI*AW)'($urandom) << AW;
        id_rs_use   = NI'($urandom);
        ex_rs       = (NE*AW)'($urandom);
        ex_rd       = AW'($urandom);
        ex_we       = ($urandom % 4) != 0;
        ex_is_load  = $urandom % 2;
        mem_rd      = AW'($urandom);
        mem_we      = ($urandom % 4) != 0;
        mem_is_load = ($urandom % 4) == 0;
        wb_rd       = AW'($urandom);
        wb_we       = ($urandom % 4) != 0;
        br_taken    = ($urandom % 8) == 0;
    endtask

    task automatic clear_inputs();
        id_rs = '0; id_rs_use = '0; ex_rs = '0; ex_rd = '0; ex_we = 0;
        ex_is_load = 0; mem_rd = '0; mem_we = 0; mem_is_load = 0;
        wb_rd = '0; wb_we = 0; br_taken = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // idle state: register-file selects, no stall, no flush (R3, R8, R9)
        check_all();

        // R4: x0 named as destination everywhere
        @(posedge clk); clear_inputs();
        mem_we = 1; wb_we = 1; ex_we = 1; ex_is_load = 1; id_rs_use = '1;
        check_all();

        // R3: both stages match, memory stage wins
        @(posedge clk); clear_inputs();
        ex_rs = {3'd5, 3'd5, 3'd5}; mem_rd = 5; mem_we = 1; wb_rd = 5; wb_we = 1;
        check_all();

        // R6: load in memory stage falls back to writeback match
        @(posedge clk); mem_is_load = 1;
        check_all();

        // R5: write-enables low
        @(posedge clk); mem_is_load = 0; mem_we = 0; wb_we = 0;
        check_all();

        // R11: only store-data operand matches
        @(posedge clk); clear_inputs();
        ex_rs = {3'd6, 3'd1, 3'd2}; mem_rd = 6; mem_we = 1;
        check_all();

        // R7: load-use on second decode source
        @(posedge clk); clear_inputs();
        id_rs = {3'd4, 3'd3}; id_rs_use = 2'b10; ex_rd = 4; ex_we = 1; ex_is_load = 1;
        check_all();

        // R8: same match, source not used
        @(posedge clk); id_rs_use = 2'b01;
        check_all();

        // R8: same match, producer is not a load
        @(posedge clk); id_rs_use = 2'b11; ex_is_load = 0;
        check_all();

        // R10: taken branch with a load-use hazard present
        @(posedge clk); ex_is_load = 1; br_taken = 1;
        check_all();

        for (int i = 0; i < 3000; i++) begin
            randomize_inputs();
            check_all();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule